// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This peripheral watches for software that has stopped making progress. Rather than counting down, it holds a 64-bit deadline and compares it on every clock against a free-running 64-bit system count that is supplied from outside. Software keeps the deadline ahead of the count by servicing the block.

When the deadline passes for the first time, the block raises a first-stage level output that is meant to interrupt software. It also pushes the deadline forward by one timeout. If the new deadline also passes without service, a second-stage level output asserts, which is meant to drive a hardware reset. Both stages stay asserted until the watchdog is serviced or disabled.

Software reaches the block over a simple 32-bit word bus with two frames. The service frame holds a single write-to-refresh location. The control frame holds the enable and status word, the timeout length in count ticks, and the deadline, which is split over two words. Both frames carry identification words. Read data is registered, so it appears one cycle after the read strobe.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the control word reads 0, the timeout word reads 0 and both stage outputs are low.
- R2: A write to control-frame offset 0x000 sets the enable from data bit 0. It also reloads the deadline with count plus timeout and clears both stages. Reading offset 0x000 returns enable in bit 0, stage one in bit 1 and stage two in bit 2, with every other bit 0.
- R3: Any write to service-frame offset 0x000 reloads the deadline with count plus timeout and clears both stages. That location reads as 0.
- R4: Control-frame offset 0x008 is the 32-bit timeout in count ticks, and it can be written and read.
- R5: The 64-bit deadline can be written and read as two words: bits 31:0 at control-frame 0x010 and bits 63:32 at 0x014. The reload sum carries across the two halves.
- R6: While enabled with stage one clear, a count that is equal to or greater than the deadline sets stage one on the next clock edge. On the same edge the deadline reloads to count plus timeout.
- R7: While stage one is set, a count that reaches the deadline sets stage two. Stage two then stays set until the block is serviced or disabled.
- R8: While disabled, no stage ever sets, whatever the count.
- R9: The first-stage output equals status bit 1 and the second-stage output equals status bit 2.
- R10: Both frames return an identification word at 0xFCC and a second ID word at 0xFE8. In the identification word, bits 19:16 are 0 (architecture version), bits 15:12 hold the revision parameter (default 3) and bits 11:0 hold the implementer parameter (default 0x43B). The second ID word is a parameter (default 0x1A).
- R11: Offsets that are not mapped read as 0, and writes to them change no state.
- R12: Read data changes only on a clock edge where the read strobe is high, and it then holds the word at the addressed location as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Free-running system count |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_frame | input | 1 | Frame select: 0 service frame, 1 control frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| stage1_irq | output | 1 | First-stage expiry level |
| stage2_rst | output | 1 | Second-stage expiry level |

## Verification
The bench probes the exact expiry edge: a count one tick short of the deadline must leave the status unchanged, and a count equal to the deadline must set stage one. A strict greater-than comparison would miss the second case. A deadline reloaded from the timeout of 0xFFFFFFFF must carry into the upper word, and a narrow adder would leave bit 32 clear. A deadline written below the count must expire at once, so an equality-only comparator would hang. Writes to unmapped offsets and to a non-service offset in the service frame must leave the stages and the timeout unchanged, and stage two must stay set while disabled expiry checking stays off.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    parameter int DW = 32;          // bus data width
    parameter int CW = 64;          // system count / deadline width
    parameter int OW = 32;          // timeout width
    parameter int AW = 12;          // frame offset width

    localparam logic [AW-1:0] OFS_STATUS  = 12'h000;
    localparam logic [AW-1:0] OFS_TIMEOUT = 12'h008;
    localparam logic [AW-1:0] OFS_DL_LO   = 12'h010;
    localparam logic [AW-1:0] OFS_DL_HI   = 12'h014;
    localparam logic [AW-1:0] OFS_IDENT   = 12'hFCC;
    localparam logic [AW-1:0] OFS_IDENT2  = 12'hFE8;

    typedef enum logic {
        FR_SERVICE = 1'b0,
        FR_CONTROL = 1'b1
    } frame_e;

    // decoded write events for one cycle
    typedef struct packed {
        logic          svc;
        logic          ctl_wr;
        logic          en_val;
        logic          tmo_wr;
        logic          dl_lo_wr;
        logic          dl_hi_wr;
        logic [DW-1:0] data;
    } wr_evt_t;

    // architectural state of the watchdog
    typedef struct packed {
        logic          en;
        logic          st1;
        logic          st2;
        logic [OW-1:0] tmo;
        logic [CW-1:0] dl;
    } wd_state_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
    import wdog_pkg::*;
(
    input  logic          wr,
    input  logic          frame,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output wr_evt_t       evt
);
    always_comb begin
        evt      = '0;
        evt.data = wdata;
        if (wr) begin
            if (frame == FR_SERVICE) begin
                evt.svc = (addr == OFS_STATUS);
            end else begin
                case (addr)
                    OFS_STATUS: begin
                        evt.svc    = 1'b1;
                        evt.ctl_wr = 1'b1;
                        evt.en_val = wdata[0];
                    end
                    OFS_TIMEOUT: evt.tmo_wr   = 1'b1;
                    OFS_DL_LO:   evt.dl_lo_wr = 1'b1;
                    OFS_DL_HI:   evt.dl_hi_wr = 1'b1;
                    default:     ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  wr_evt_t       evt,
    output wd_state_t     st_q
);
    localparam int PADW = CW - OW;

    wd_state_t     st_d;
    logic [CW-1:0] reload;
    logic          expired;

    always_comb begin
        st_d    = st_q;
        reload  = count + {{PADW{1'b0}}, st_q.tmo};
        expired = st_q.en && (count >= st_q.dl);
        if (evt.tmo_wr) begin
            st_d.tmo = evt.data[OW-1:0];
        end
        if (evt.svc) begin
            st_d.dl  = reload;
            st_d.st1 = 1'b0;
            st_d.st2 = 1'b0;
            if (evt.ctl_wr) begin
                st_d.en = evt.en_val;
            end
        end else if (evt.dl_lo_wr) begin
            st_d.dl[DW-1:0] = evt.data;
        end else if (evt.dl_hi_wr) begin
            st_d.dl[CW-1:DW] = evt.data;
        end else if (expired) begin
            if (!st_q.st1) begin
                st_d.st1 = 1'b1;
                st_d.dl  = reload;
            end else begin
                st_d.st2 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ST2_NEEDS_ST1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.st2 |-> st_q.st1); // R7
    AST_ST2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st2 && !evt.svc) |=> st_q.st2); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (!st_q.st1 && !st_q.st2)); // R8
    AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evt.svc |=> (!st_q.st1 && !st_q.st2)); // R3
    AST_ST1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.st1) |-> $past(st_q.en && (count >= st_q.dl))); // R6
    AST_ST1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.st1) |-> (st_q.dl == $past(count) + {{PADW{1'b0}}, $past(st_q.tmo)})); // R6
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter logic [3:0]  REV   = 4'h3,
    parameter logic [11:0] IMPL  = 12'h43B,
    parameter logic [31:0] IDENT2 = 32'h0000_001A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          frame,
    input  logic [AW-1:0] addr,
    input  wd_state_t     st,
    output logic [DW-1:0] rdata_q
);
    localparam logic [3:0]    ARCH_VER = 4'h0;
    localparam logic [DW-1:0] IDENT    = {12'h000, ARCH_VER, REV, IMPL};

    logic [DW-1:0] rdata_d;
    logic [DW-1:0] word;

    always_comb begin
        word = '0;
        case (addr)
            OFS_IDENT:  word = IDENT;
            OFS_IDENT2: word = IDENT2;
            default: begin
                if (frame == FR_CONTROL) begin
                    case (addr)
                        OFS_STATUS:  word = {{(DW-3){1'b0}}, st.st2, st.st1, st.en};
                        OFS_TIMEOUT: word = st.tmo;
                        OFS_DL_LO:   word = st.dl[DW-1:0];
                        OFS_DL_HI:   word = st.dl[CW-1:DW];
                        default:     word = '0;
                    endcase
                end
            end
        endcase
        rdata_d = rd ? word : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata_q)); // R12
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter logic [3:0]  REV    = 4'h3,
    parameter logic [11:0] IMPL   = 12'h43B,
    parameter logic [31:0] IDENT2 = 32'h0000_001A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [63:0]   sys_count,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_frame,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          stage1_irq,
    output logic          stage2_rst
);
    wr_evt_t   evt;
    wd_state_t st;

    wdog_decode u_decode (
        .wr    (bus_wr),
        .frame (bus_frame),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .evt   (evt)
    );

    wdog_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .count (sys_count),
        .evt   (evt),
        .st_q  (st)
    );

    wdog_rdmux #(
        .REV    (REV),
        .IMPL   (IMPL),
        .IDENT2 (IDENT2)
    ) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .frame   (bus_frame),
        .addr    (bus_addr),
        .st      (st),
        .rdata_q (bus_rdata)
    );

    assign stage1_irq = st.st1;
    assign stage2_rst = st.st2;

    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage2_rst) |-> $past(stage1_irq)); // R9
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cnt;
    logic        wr_en, rd_en, frame_sel;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        s1o, s2o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    wdog_two_stage u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_count  (cnt),
        .bus_wr     (wr_en),
        .bus_rd     (rd_en),
        .bus_frame  (frame_sel),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .stage1_irq (s1o),
        .stage2_rst (s2o)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic f, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        frame_sel = f; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: queue the expected word, then issue the read
    task automatic rd(logic f, logic [11:0] a, logic [31:0] e, string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        frame_sel = f; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cnt(logic [63:0] v);
        @(negedge clk);
        cnt = v;
    endtask

    // monitor: data registered on the strobe edge, compared just after it
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                #2;
                if (exp_q.size() == 0) begin
                    chk("scoreboard underflow", 64'd1, 64'd0);
                end else begin
                    chk(tag_q.pop_front(), {32'h0, rdata}, {32'h0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt = 64'd1000; wr_en = 1'b0; rd_en = 1'b0;
        frame_sel = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b1, 12'h000, 32'h0, "R1 control after reset");
        rd(1'b1, 12'h008, 32'h0, "R1 timeout after reset");
        chk("R1 stage1 after reset", s1o, 0);
        chk("R1 stage2 after reset", s2o, 0);

        // R10 identification in both frames
        rd(1'b0, 12'hFCC, 32'h0000_343B, "R10 ident service frame");
        rd(1'b1, 12'hFCC, 32'h0000_343B, "R10 ident control frame");
        rd(1'b0, 12'hFE8, 32'h0000_001A, "R10 ident2 service frame");
        rd(1'b1, 12'hFE8, 32'h0000_001A, "R10 ident2 control frame");

        // R11 unmapped offset
        wr(1'b1, 12'h004, 32'hFFFF_FFFF);
        rd(1'b1, 12'h004, 32'h0, "R11 unmapped reads zero");
        rd(1'b1, 12'h000, 32'h0, "R11 unmapped write leaves control");

        // R4, R2 program and enable
        wr(1'b1, 12'h008, 32'd100);
        rd(1'b1, 12'h008, 32'd100, "R4 timeout readback");
        wr(1'b1, 12'h000, 32'h1);
        rd(1'b1, 12'h000, 32'h1, "R2 enabled status");
        rd(1'b1, 12'h010, 32'd1100, "R2 deadline reload low");
        rd(1'b1, 12'h014, 32'd0, "R5 deadline reload high");

        // R6 boundary: one short, then equal
        set_cnt(64'd1099);
        idle(2);
        rd(1'b1, 12'h000, 32'h1, "R6 no expiry one tick short");
        set_cnt(64'd1100);
        idle(2);
        rd(1'b1, 12'h000, 32'h3, "R6 stage one at equal count");
        rd(1'b1, 12'h010, 32'd1200, "R6 deadline pushed forward");
        chk("R9 stage1 pin", s1o, 1);
        chk("R9 stage2 pin", s2o, 0);

        // R3 service frame refresh
        set_cnt(64'd1150);
        wr(1'b0, 12'h000, 32'h0);
        rd(1'b1, 12'h000, 32'h1, "R3 refresh clears stage");
        rd(1'b1, 12'h010, 32'd1250, "R3 refresh reloads deadline");
        rd(1'b0, 12'h000, 32'h0, "R3 refresh location reads zero");

        // R7 second stage and stickiness
        set_cnt(64'd1250);
        idle(2);
        rd(1'b1, 12'h010, 32'd1350, "R6 second reload");
        set_cnt(64'd1350);
        idle(2);
        rd(1'b1, 12'h000, 32'h7, "R7 stage two set");
        chk("R9 stage1 pin both", s1o, 1);
        chk("R9 stage2 pin both", s2o, 1);
        idle(4);
        rd(1'b1, 12'h000, 32'h7, "R7 stage two sticky");

        // R2 control write clears
        wr(1'b1, 12'h000, 32'h1);
        rd(1'b1, 12'h000, 32'h1, "R2 control write clears stages");

        // R8 disabled
        wr(1'b1, 12'h000, 32'h0);
        set_cnt(64'd5000);
        idle(3);
        rd(1'b1, 12'h000, 32'h0, "R8 disabled no expiry");
        chk("R8 stage1 pin disabled", s1o, 0);
        chk("R8 stage2 pin disabled", s2o, 0);

        // R5 carry across halves
        wr(1'b1, 12'h008, 32'hFFFF_FFFF);
        set_cnt(64'h0000_0001_0000_0010);
        wr(1'b1, 12'h000, 32'h1);
        rd(1'b1, 12'h010, 32'h0000_000F, "R5 carry low word");
        rd(1'b1, 12'h014, 32'h0000_0002, "R5 carry high word");

        // R5, R6 deadline written below count expires
        wr(1'b1, 12'h014, 32'h0);
        idle(2);
        rd(1'b1, 12'h000, 32'h3, "R6 past deadline expires");
        rd(1'b1, 12'h014, 32'h0000_0002, "R5 high word after reload");

        // R11 non-service offset in service frame
        wr(1'b0, 12'h008, 32'h5);
        rd(1'b1, 12'h000, 32'h3, "R11 service-frame offset no refresh");
        rd(1'b1, 12'h008, 32'hFFFF_FFFF, "R11 timeout untouched");
        rd(1'b0, 12'h008, 32'h0, "R11 service-frame offset reads zero");

        // R12 read data holds without strobe
        idle(3);
        chk("R12 read data held", rdata, 32'h0);

        idle(2);
        if (exp_q.size() != 0) chk("scoreboard leftovers", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule